// File: doc/BRIEF.md
# Single-Flip Gray Code Counter

This block is a synchronous up-counter that keeps its state directly as a reflected Gray code word. It has no binary count inside and never forms one. On each clock where counting is enabled, exactly one stored bit flips. A small selection network picks that bit from two inputs: a stored parity flag and the position of the lowest set bit of the present word. The network drives a per-bit toggle enable into a bank of toggle flip-flops.

The parity flag has its own flip-flop and inverts on every counted clock, so no XOR reduction tree is needed each cycle. The flag is also an output, and it equals the least significant bit of the equivalent binary count. The width is a parameter. The counter runs through every code of that width and then returns to zero.

Typical uses are low-activity event counting and pointers that other logic samples without a handshake.

Top module: `gray_toggle_counter`

## Requirements
- R1: When `clr_i` is high at a rising clock edge, `gray_o` becomes all zeros and `parity_o` becomes 0 after that edge, whatever the value of `en_i` (clear wins over enable).
- R2: When `en_i` is low and `clr_i` is low at an edge, `gray_o` and `parity_o` keep their values.
- R3: Every enabled edge without clear changes exactly one bit of `gray_o`.
- R4: On an enabled edge where `parity_o` is 0 (even number of ones in `gray_o`), bit 0 of `gray_o` toggles.
- R5: On an enabled edge where `parity_o` is 1 and the lowest 1 of `gray_o` sits at position k with k < WIDTH-2, bit k+1 toggles.
- R6: On an enabled edge where `parity_o` is 1 and the lowest 1 sits at position WIDTH-2 or WIDTH-1, bit WIDTH-1 (the MSB) toggles. In particular the word with only the MSB set steps to all zeros.
- R7: After a clear followed by b enabled edges, `gray_o` equals g ^ (g >> 1), where g = b mod 2^WIDTH. All 2^WIDTH codes therefore appear before the sequence repeats.
- R8: `parity_o` is a register output equal to the XOR of all bits of `gray_o`, which is also bit 0 of the count b from R7.
- R9: WIDTH below 2 is rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| clr_i | input | 1 | Synchronous clear to code zero |
| en_i | input | 1 | Count enable; one step per high edge |
| gray_o | output | WIDTH | Stored Gray code word |
| parity_o | output | 1 | Registered parity of `gray_o` |

## Verification
The counter is driven by three input patterns.

An unbroken enable run covers more than one full period. It shows that every code appears and that the MSB-only word wraps to zero.

A sparse random enable pattern mixes hold cycles with counting. It separates a counter that advances on every clock from one that respects the enable, and it checks that the parity flag stays in step across those gaps.

A clear is asserted in the middle of a count while enable is high. It checks that clear takes priority.

On every step the changed bit is sorted into the even-parity rule, the rule for a lowest 1 below the top two positions, or the top-two rule. That sorting points to the selection path that failed.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
   // Smallest width for which the lowest-set-bit rule is defined
   localparam int unsigned GCNT_MIN_WIDTH = 2;
endpackage

// File: rtl/gcnt_toggle_sel.sv
module gcnt_toggle_sel #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] code_i,
   input  logic             parity_i,
   input  logic             step_i,
   output logic [WIDTH-1:0] tgl_o
);
   localparam int unsigned TOP = WIDTH - 1;

   logic [WIDTH-1:0] lower_any;   // some bit below position i is set
   logic [WIDTH-1:0] lowest_hot;  // one-hot marker of the lowest set bit

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_scan
         if (i == 0) begin : g_first
            assign lower_any[i] = 1'b0;
         end else begin : g_rest
            assign lower_any[i] = lower_any[i-1] | code_i[i-1];
         end
         assign lowest_hot[i] = code_i[i] & ~lower_any[i];
      end

      for (genvar i = 0; i < WIDTH; i++) begin : g_tgl
         if (i == 0) begin : g_lsb
            assign tgl_o[i] = step_i & ~parity_i;
         end else if (i < TOP) begin : g_mid
            assign tgl_o[i] = step_i & parity_i & lowest_hot[i-1];
         end else begin : g_msb
            assign tgl_o[i] = step_i & parity_i & (lowest_hot[i-1] | lowest_hot[i]);
         end
      end
   endgenerate

   AST_TGL_ONE_HOT: assert property (@(posedge clk_i) disable iff (clr_i)
      step_i |-> ($countones(tgl_o) == 1)); // R3

   AST_IDLE_NO_TGL: assert property (@(posedge clk_i) disable iff (clr_i)
      !step_i |-> (tgl_o == '0)); // R2
endmodule

// File: rtl/gcnt_tff_bank.sv
module gcnt_tff_bank #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] tgl_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_tff
         always_ff @(posedge clk_i) begin
            if (clr_i) begin
               q_o[i] <= 1'b0;
            end else if (tgl_i[i]) begin
               q_o[i] <= ~q_o[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gcnt_parity_reg.sv
module gcnt_parity_reg (
   input  logic clk_i,
   input  logic clr_i,
   input  logic step_i,
   output logic q_o
);
   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         q_o <= 1'b0;
      end else if (step_i) begin
         q_o <= ~q_o;
      end
   end
endmodule

// File: rtl/gray_toggle_counter.sv
module gray_toggle_counter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             clr_i,
   input  logic             en_i,
   output logic [WIDTH-1:0] gray_o,
   output logic             parity_o
);
   import gcnt_pkg::*;

   localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      if (WIDTH < GCNT_MIN_WIDTH) begin : g_bad_width
         $error("gray_toggle_counter: WIDTH must be at least 2"); // R9
      end
   endgenerate

   logic [WIDTH-1:0] tgl;

   gcnt_toggle_sel #(.WIDTH(WIDTH)) u_sel (
      .clk_i   (clk_i),
      .clr_i   (clr_i),
      .code_i  (gray_o),
      .parity_i(parity_o),
      .step_i  (en_i),
      .tgl_o   (tgl)
   );

   gcnt_tff_bank #(.WIDTH(WIDTH)) u_bank (
      .clk_i(clk_i),
      .clr_i(clr_i),
      .tgl_i(tgl),
      .q_o  (gray_o)
   );

   gcnt_parity_reg u_par (
      .clk_i (clk_i),
      .clr_i (clr_i),
      .step_i(en_i),
      .q_o   (parity_o)
   );

   AST_CLEAR_ZERO: assert property (@(posedge clk_i)
      clr_i |=> (gray_o == '0 && !parity_o)); // R1

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (clr_i)
      !en_i |=> ($stable(gray_o) && $stable(parity_o))); // R2

   AST_SINGLE_FLIP: assert property (@(posedge clk_i) disable iff (clr_i)
      en_i |=> ($countones(gray_o ^ $past(gray_o)) == 1)); // R3

   AST_EVEN_LSB: assert property (@(posedge clk_i) disable iff (clr_i)
      (en_i && !parity_o) |=> (gray_o[0] != $past(gray_o[0]))); // R4

   AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (clr_i)
      (en_i && gray_o == MSB_ONLY) |=> (gray_o == '0)); // R6

   AST_PARITY_MATCH: assert property (@(posedge clk_i) disable iff (clr_i)
      parity_o == ^gray_o); // R8
endmodule

// File: tb/gray_toggle_counter_tb.sv
module gray_toggle_counter_tb;
   localparam int W   = 8;
   localparam int MOD = 1 << W;

   logic         clk = 1'b0;
   logic         clr = 1'b1;
   logic         en  = 1'b0;
   logic [W-1:0] gray;
   logic         par;

   int checks = 0;
   int errors = 0;
   int b = 0;
   int cycles = 0;
   bit done = 0;
   logic [W-1:0] prev_gray;
   int prev_b = 0;
   bit seen [MOD];

   always #4 clk = ~clk;

   gray_toggle_counter #(.WIDTH(W)) u_dut (
      .clk_i(clk), .clr_i(clr), .en_i(en), .gray_o(gray), .parity_o(par)
   );

   function automatic logic [W-1:0] to_gray(input int v);
      logic [W-1:0] x;
      x = v[W-1:0];
      return x ^ (x >> 1);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic e, input logic c);
      logic [W-1:0] diff;
      int k;
      en = e; clr = c;
      prev_gray = gray;
      prev_b = b;
      @(negedge clk);
      cycles++;
      if (c) b = 0;
      else if (e) b = (b + 1) % MOD;
      chk(gray == to_gray(b), "R7 code", gray, to_gray(b));
      chk(par == b[0], "R8 parity", par, b[0]);
      if (c) begin
         chk(gray == '0 && par == 1'b0, "R1 clear", {par, gray}, 0);
      end else if (!e) begin
         chk(gray == prev_gray, "R2 hold", gray, prev_gray);
      end else begin
         diff = gray ^ prev_gray;
         chk($countones(diff) == 1, "R3 one bit", diff, 1);
         if (prev_b[0] == 1'b0) begin
            chk(diff == 1, "R4 even lsb", diff, 1);
         end else begin
            k = 0;
            for (int i = W - 1; i >= 0; i--) if (prev_gray[i]) k = i;
            if (k < W - 2) chk(diff == (1 << (k + 1)), "R5 above lowest", diff, 1 << (k + 1));
            else           chk(diff == (1 << (W - 1)), "R6 msb", diff, 1 << (W - 1));
         end
      end
   endtask

   initial begin
      @(negedge clk);
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);               // R1: clear beats enable
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0); // R2
      for (int i = 0; i < MOD; i++) seen[i] = 0;
      seen[gray] = 1;
      for (int i = 0; i < MOD; i++) begin
         step(1'b1, 1'b0);
         seen[gray] = 1;
      end
      begin : full_period
         int n = 0;
         for (int i = 0; i < MOD; i++) n += seen[i];
         chk(n == MOD, "R7 all codes", n, MOD);
         chk(gray == '0, "R6 wrap to zero", gray, 0);
      end
      for (int i = 0; i < 700; i++) step(($urandom % 3) != 0, 1'b0);
      step(1'b1, 1'b1);               // R1 mid-count clear
      for (int i = 0; i < 3 * MOD / 2; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 200; i++) step(($urandom % 4) == 0, 1'b0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule